// File: doc/BRIEF.md
# MDIO Station-Management Master

This block runs single register reads and writes to an external Ethernet PHY over the two-wire management bus. It derives the management clock (MDC) from the system clock, serialises one complete frame per command, controls the direction of the shared data line, and captures read data into its data register.

Software sees two registers. The data register holds the value for a write and receives the result of a read. The command register holds the PHY address, the PHY register number, a direction flag, a clock-range code and a busy flag. Writing the command register with the busy flag set starts a frame. Hardware clears busy when the last bit period ends, and software polls busy before it issues the next command or picks up read data. The MDC divide ratio comes from a small fixed set. Software picks the ratio by the range of the system clock: 16 for at least 20 MHz, 26 for at least 35 MHz, 42 for at least 60 MHz, 62 for at least 100 MHz and 102 for at least 150 MHz. System clocks below 20 MHz are not supported.

Top module: `mdio_master`

## Requirements
- R1: After reset, the command readback and the data register read zero, MDC is low and the data line is not driven (`mdio_oe` low).
- R2: The command word is laid out as follows: bits 15:11 hold the PHY address, bits 10:6 the register number, bits 5:2 the clock-range code, bit 1 the write flag (1 = write, 0 = read) and bit 0 the busy flag. A command accepted while idle reads back with the same fields.
- R3: Range codes 0, 1, 2 and 3 give an MDC period of 16, 26, 42 and 62 system clocks. Codes 4 to 15 give 102. MDC stays low while idle.
- R4: A write frame is 64 bits, sent MSB first: 32 ones, start 01, opcode 01, PHY address, register number, turnaround 10, then the 16 bits of the data register. The data register value used is the one present when the command is accepted, and a data write in the same cycle as the command counts.
- R5: A read frame sends opcode 10 and releases the line (`mdio_oe` low) for the two turnaround periods and the 16 data periods. It samples `mdio_i` on each rising MDC edge of the data phase, MSB first, and the 16-bit result is in the data register when busy clears.
- R6: Writing the command register with bit 0 set while idle sets busy on the next cycle. Busy clears exactly 64 MDC periods after the accepting clock edge. `mdio_oe` is high only while busy.
- R7: A command write while busy is ignored. The frame in progress and the command readback are unchanged.
- R8: A data-register write while busy is ignored.
- R9: A command write with bit 0 clear, while idle, updates the stored fields and starts no frame.
- R10: `mdio_o` and `mdio_oe` change only while MDC is low (at MDC falling edges, or at the start of a frame). They are stable for the whole high phase of MDC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 16 | Command word to write |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 16 | Data word to write |
| cmd_rdata | output | 16 | Command register readback, bit 0 = busy |
| data_rdata | output | 16 | Data register readback |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable (high = driven) |
| mdio_i | input | 1 | Data line input value |

## Verification
The properties assume that the PHY side presents a known level on `mdio_i` at every rising MDC edge of a read data phase, and that software keeps the range code constant over a frame. Software cannot break the second assumption, because command writes are dropped while busy. The bench's PHY model holds the line at the pulled-up level of 1. It pulls the line low for the second turnaround period and drives data bits only during a read. It changes `mdio_i` just after a rising MDC edge, so every value is steady for a full MDC period before the next sample.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int PHY_AW  = 5,
  parameter int REG_AW  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32,
  parameter int DIV0    = 16,
  parameter int DIV1    = 26,
  parameter int DIV2    = 42,
  parameter int DIV3    = 62,
  parameter int DIV4    = 102,
  localparam int CMD_W  = 6 + REG_AW + PHY_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_wdata,
  output logic [CMD_W-1:0]  cmd_rdata,
  output logic [DATA_W-1:0] data_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int REG_LSB   = 6;
  localparam int PHY_LSB   = REG_LSB + REG_AW;
  localparam int FRAME_LEN = PRE_LEN + 4 + PHY_AW + REG_AW + 2 + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int HALF_W    = $clog2(DIV4 / 2 + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(FRAME_LEN - DATA_W);
  localparam logic [IDX_W-1:0] PRE_TA   = IDX_W'(FRAME_LEN - DATA_W - 3);

  logic [PHY_AW-1:0]    phy_q;
  logic [REG_AW-1:0]    reg_q;
  logic [3:0]           rng_q;
  logic                 wr_q, busy_q, mdc_q, out_q, oe_q;
  logic [DATA_W-1:0]    data_q;
  logic [FRAME_LEN-1:0] sh_q;
  logic [IDX_W-1:0]     idx_q;
  logic [HALF_W-1:0]    cnt_q;

  function automatic logic [HALF_W-1:0] half_of(input logic [3:0] code);
    case (code)
      4'd0:    half_of = HALF_W'(DIV0 / 2);
      4'd1:    half_of = HALF_W'(DIV1 / 2);
      4'd2:    half_of = HALF_W'(DIV2 / 2);
      4'd3:    half_of = HALF_W'(DIV3 / 2);
      default: half_of = HALF_W'(DIV4 / 2);
    endcase
  endfunction

  wire                 start   = cmd_we && cmd_wdata[0] && !busy_q;
  wire [DATA_W-1:0]    data_nx = data_we ? data_wdata : data_q;
  wire [HALF_W-1:0]    half_w  = half_of(rng_q);
  wire                 tick    = (cnt_q == half_w - 1'b1);
  wire [FRAME_LEN-1:0] frame_w = {{PRE_LEN{1'b1}}, 2'b01,
                                  cmd_wdata[1] ? 2'b01 : 2'b10,
                                  cmd_wdata[PHY_LSB +: PHY_AW],
                                  cmd_wdata[REG_LSB +: REG_AW],
                                  2'b10, data_nx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_q  <= '0;
      reg_q  <= '0;
      rng_q  <= '0;
      wr_q   <= 1'b0;
      busy_q <= 1'b0;
      data_q <= '0;
      mdc_q  <= 1'b0;
      out_q  <= 1'b0;
      oe_q   <= 1'b0;
      sh_q   <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (cmd_we) begin
        phy_q <= cmd_wdata[PHY_LSB +: PHY_AW];
        reg_q <= cmd_wdata[REG_LSB +: REG_AW];
        rng_q <= cmd_wdata[5:2];
        wr_q  <= cmd_wdata[1];
      end
      if (data_we) data_q <= data_wdata;
      if (start) begin
        busy_q <= 1'b1;
        out_q  <= frame_w[FRAME_LEN-1];
        sh_q   <= frame_w << 1;
        oe_q   <= 1'b1;
        mdc_q  <= 1'b0;
        idx_q  <= '0;
        cnt_q  <= '0;
      end
    end else if (!tick) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
      if (!mdc_q) begin
        mdc_q <= 1'b1;
        if (!wr_q && idx_q >= DATA_IDX)
          data_q <= {data_q[DATA_W-2:0], mdio_i};
      end else begin
        mdc_q <= 1'b0;
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
          out_q  <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
          out_q <= sh_q[FRAME_LEN-1];
          sh_q  <= sh_q << 1;
          if (!wr_q && idx_q == PRE_TA) oe_q <= 1'b0;
        end
      end
    end
  end

  assign cmd_rdata  = {phy_q, reg_q, rng_q, wr_q, busy_q};
  assign data_rdata = data_q;
  assign mdc        = mdc_q;
  assign mdio_o     = out_q;
  assign mdio_oe    = oe_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int CMD_W  = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_we,
  input logic              cmd_go,
  input logic [CMD_W-1:0]  cmd_rdata,
  input logic [DATA_W-1:0] data_rdata,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe
);
  wire busy = cmd_rdata[0];

  a_r3_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r6_oe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);

  a_r6_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_go && !busy) |=> busy);

  a_r7_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_rdata[CMD_W-1:1]));

  a_r8_wdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && cmd_rdata[1]) |-> $stable(data_rdata));

  a_r10_launch_low: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_master mdio_master_chk #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_go(cmd_wdata[0]),
  .cmd_rdata(cmd_rdata), .data_rdata(data_rdata), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [15:0] cmd_wdata = '0;
  logic        data_we = 1'b0;
  logic [15:0] data_wdata = '0;
  logic [15:0] cmd_rdata, data_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mdio_master uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .cmd_rdata(cmd_rdata),
    .data_rdata(data_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model and frame recorder
  int          rise_n = 0;
  int          glitch = 0;
  logic [63:0] fo, foe;
  realtime     t0, t1;
  bit          rd_mode = 0;
  logic [15:0] rd_val = '0;
  logic        hi_o, hi_oe;

  function automatic logic phy_bit(input int k);
    if (!rd_mode) return 1'b1;
    if (k == 47) return 1'b0;
    if (k >= 48 && k <= 63) return rd_val[63-k];
    return 1'b1;
  endfunction

  always @(posedge mdc) begin
    if (rise_n < 64) begin
      fo[63-rise_n]  = mdio_o;
      foe[63-rise_n] = mdio_oe;
    end
    if (rise_n == 0) t0 = $realtime;
    if (rise_n == 1) t1 = $realtime;
    hi_o   = mdio_o;
    hi_oe  = mdio_oe;
    rise_n = rise_n + 1;
    mdio_i = phy_bit(rise_n);
  end

  always @(negedge clk)
    if (mdc && (mdio_o !== hi_o || mdio_oe !== hi_oe)) glitch = glitch + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int div_of(input logic [3:0] code);
    case (code)
      4'd0: return 16;
      4'd1: return 26;
      4'd2: return 42;
      4'd3: return 62;
      default: return 102;
    endcase
  endfunction

  // meddle: drive a different command and data mid-frame (R7, R8)
  task automatic run_frame(input logic [4:0] phy, input logic [4:0] rg,
                           input logic [3:0] rng, input logic wr,
                           input logic [15:0] val, input bit meddle);
    logic [63:0] exp;
    int n;
    int dv = div_of(rng);
    rd_mode = !wr;
    rd_val  = val;
    rise_n  = 0;
    glitch  = 0;
    fo = '0; foe = '0;
    exp = {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, rg, 2'b10, val};
    @(negedge clk);
    data_we = wr; data_wdata = val;
    cmd_we = 1'b1; cmd_wdata = {phy, rg, rng, wr, 1'b1};
    @(negedge clk);
    data_we = 1'b0; cmd_we = 1'b0;
    chk("R6 busy set after accept", 64'(cmd_rdata[0]), 64'd1);
    n = 0;
    while (cmd_rdata[0] && n < 20000) begin
      @(negedge clk);
      n++;
      if (meddle && n == 300) begin
        cmd_we = 1'b1; cmd_wdata = {~phy, ~rg, 4'd1, ~wr, 1'b1};
        data_we = 1'b1; data_wdata = ~val;
      end
      if (meddle && n == 301) begin
        cmd_we = 1'b0; data_we = 1'b0;
      end
    end
    chk("R6 busy duration", 64'(n), 64'(64 * dv));
    chk("R3 MDC period", 64'(int'((t1 - t0) / 5.0)), 64'(dv));
    chk("R6 bit periods", 64'(rise_n), 64'd64);
    chk("R3 MDC low when idle", 64'(mdc), 64'd0);
    chk("R6 line released when idle", 64'(mdio_oe), 64'd0);
    chk("R10 line stable while MDC high", 64'(glitch), 64'd0);
    chk("R2 command readback", 64'(cmd_rdata), 64'({phy, rg, rng, wr, 1'b0}));
    if (wr) begin
      chk("R4 write frame bits", fo, exp);
      chk("R4 write frame driven", foe, '1);
      chk("R8 data register kept", 64'(data_rdata), 64'(val));
    end else begin
      chk("R5 read frame header", 64'(fo[63:18]), 64'(exp[63:18]));
      chk("R5 read drive pattern", foe, {46'h3FFF_FFFF_FFFF, 18'h0});
      chk("R5 read data captured", 64'(data_rdata), 64'(val));
    end
    rd_mode = 0;
  endtask

  task automatic t_reset;
    chk("R1 cmd readback at reset", 64'(cmd_rdata), 64'd0);
    chk("R1 data at reset", 64'(data_rdata), 64'd0);
    chk("R1 mdc at reset", 64'(mdc), 64'd0);
    chk("R1 oe at reset", 64'(mdio_oe), 64'd0);
  endtask

  task automatic t_no_start;
    rise_n = 0;
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = {5'h0C, 5'h15, 4'd2, 1'b1, 1'b0};
    @(negedge clk);
    cmd_we = 1'b0;
    repeat (200) @(negedge clk);
    chk("R9 no frame without busy bit", 64'(rise_n), 64'd0);
    chk("R9 fields stored", 64'(cmd_rdata), 64'({5'h0C, 5'h15, 4'd2, 1'b1, 1'b0}));
  endtask

  initial begin
    #750000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_frame(5'h01, 5'h00, 4'd0, 1'b1, 16'hA5C3, 0);
    run_frame(5'h1F, 5'h02, 4'd1, 1'b0, 16'h1234, 0);
    run_frame(5'h10, 5'h1F, 4'd2, 1'b1, 16'h8001, 0);
    run_frame(5'h03, 5'h11, 4'd3, 1'b0, 16'hFFFE, 0);
    run_frame(5'h15, 5'h0A, 4'd4, 1'b0, 16'h0001, 0);
    run_frame(5'h06, 5'h19, 4'd0, 1'b1, 16'h3C5A, 1);
    t_no_start();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule